// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a physical address by walking a two-level translation structure held in ordinary word-addressed memory. A loadable root register holds the physical base of the top-level directory. Each request reads one directory word, then one leaf table word. The block then joins the leaf's frame number with the in-page byte offset and returns the result on a response port.

While it walks, the block applies the leaf permissions. A store to a page marked read-only ends with a protection fault, and memory is left untouched. The first touch of a page sets its accessed flag, and the first store sets its modified flag. Both flags are written back to memory with one word write, and only when the word actually changes. A missing entry at either level ends the walk early with a not-present fault that names the level.

Requests are taken one at a time through a valid/ready handshake. The memory port is one word wide and returns read data on the clock after the read strobe, as a synchronous RAM does.

Top module: `pt_walker`

## Requirements
- R1: Virtual address bits 31:22 select the directory slot and bits 21:12 select the leaf slot. The first memory read of a walk goes to root + slot*4, using the root value held when the request is accepted.
- R2: A pulse on `root_load` replaces the root with `root_value`. Every later walk reads its directory word relative to the new root.
- R3: For a present directory word, the second read goes to {word[31:12], 12'h000} + leaf slot*4.
- R4: A successful walk responds with `rsp_fault` = 2'b00, `rsp_level` = 0 and `rsp_paddr` = {leaf[31:12], vaddr[11:0]}.
- R5: Entry bit 0 is the present flag. A directory word with bit 0 clear ends the walk after a single read, with `rsp_fault` = 2'b01 and `rsp_level` = 0.
- R6: A leaf word with bit 0 clear ends the walk with `rsp_fault` = 2'b01 and `rsp_level` = 1, and nothing is written.
- R7: Leaf bit 1 is the write-enable flag. A store request whose leaf has bit 1 clear responds with `rsp_fault` = 2'b10 and `rsp_level` = 1, and memory is not written.
- R8: After a permitted access, the leaf word is rewritten at its own address with bit 5 (accessed) set, and also with bit 6 (modified) set for a store. All other bits are kept.
- R9: When the leaf already holds every flag the access needs, no memory write takes place.
- R10: `req_ready` is low from the cycle after acceptance until the cycle after the one-cycle `rsp_valid` pulse. Each accepted request gets exactly one response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| root_load | input | 1 | Load strobe for the directory root |
| root_value | input | 32 | Physical address of the directory |
| req_valid | input | 1 | Translation request valid |
| req_ready | output | 1 | Walker idle and able to accept |
| req_vaddr | input | 32 | Virtual address to translate |
| req_write | input | 1 | Request is a store |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_paddr | output | 32 | Translated physical address |
| rsp_fault | output | 2 | 00 ok, 01 not present, 10 write protected |
| rsp_level | output | 1 | 0 directory / success, 1 leaf |
| mem_rd_en | output | 1 | Memory read strobe |
| mem_wr_en | output | 1 | Memory write strobe |
| mem_addr | output | 32 | Byte address of the word accessed |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid the cycle after the strobe |

## Verification
The hard path is the one where write-back is skipped. It needs a leaf whose accessed and modified flags already match the access, reached through a present directory word. Random leaf flags rarely line up with the request type, so half of the random requests reuse a small pool of addresses. A page that an earlier walk marked is then walked again, and the bench's own memory image shows whether a write should appear. Directed cases also set up each fault level and a read-only store on a clean page, so that a protection fault must suppress a write that would otherwise be needed.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
  localparam int unsigned WORD_W  = 32;
  localparam int unsigned OFF_W   = 12;
  localparam int unsigned IDX_W   = 10;
  localparam int unsigned FRAME_W = WORD_W - OFF_W;

  localparam int unsigned BIT_PRESENT  = 0;
  localparam int unsigned BIT_WRITABLE = 1;
  localparam int unsigned BIT_ACCESSED = 5;
  localparam int unsigned BIT_MODIFIED = 6;

  typedef enum logic [1:0] {
    FLT_NONE   = 2'b00,
    FLT_ABSENT = 2'b01,
    FLT_PROT   = 2'b10
  } fault_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_DIR_RD, ST_DIR_CHK, ST_LEAF_RD, ST_LEAF_CHK, ST_WB, ST_RSP
  } walk_state_e;
endpackage

// File: rtl/ptw_addr_gen.sv
module ptw_addr_gen #(
  parameter int unsigned W     = ptw_pkg::WORD_W,
  parameter int unsigned IDX_W = ptw_pkg::IDX_W,
  parameter int unsigned OFF_W = ptw_pkg::OFF_W
) (
  input  logic [W-1:0] root,
  input  logic [W-1:0] vaddr,
  input  logic [W-1:0] dir_word,
  output logic [W-1:0] dir_addr,
  output logic [W-1:0] leaf_addr
);
  localparam int unsigned PAD_W = W - IDX_W - 2;

  logic [IDX_W-1:0] dir_slot;
  logic [IDX_W-1:0] leaf_slot;

  assign dir_slot  = vaddr[W-1 -: IDX_W];
  assign leaf_slot = vaddr[OFF_W +: IDX_W];

  assign dir_addr  = root + {{PAD_W{1'b0}}, dir_slot, 2'b00};
  assign leaf_addr = {dir_word[W-1:OFF_W], {OFF_W{1'b0}}}
                   + {{PAD_W{1'b0}}, leaf_slot, 2'b00};
endmodule

// File: rtl/ptw_entry_eval.sv
module ptw_entry_eval
  import ptw_pkg::*;
#(
  parameter int unsigned W = WORD_W
) (
  input  logic [W-1:0] entry,
  input  logic         is_store,
  input  logic         at_leaf,
  output fault_e       fault,
  output logic [W-1:0] upd_word,
  output logic         need_wb
);
  logic [W-1:0] flag_set;

  always_comb begin
    flag_set = '0;
    flag_set[BIT_ACCESSED] = 1'b1;
    flag_set[BIT_MODIFIED] = is_store;
    upd_word = entry | flag_set;

    if (!entry[BIT_PRESENT])
      fault = FLT_ABSENT;
    else if (at_leaf && is_store && !entry[BIT_WRITABLE])
      fault = FLT_PROT;
    else
      fault = FLT_NONE;

    need_wb = at_leaf && (fault == FLT_NONE) && (upd_word != entry);
  end
endmodule

// File: rtl/pt_walker.sv
module pt_walker
  import ptw_pkg::*;
#(
  parameter int unsigned W     = WORD_W,
  parameter int unsigned IDX_W = ptw_pkg::IDX_W,
  parameter int unsigned OFF_W = ptw_pkg::OFF_W
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         root_load,
  input  logic [W-1:0] root_value,
  input  logic         req_valid,
  output logic         req_ready,
  input  logic [W-1:0] req_vaddr,
  input  logic         req_write,
  output logic         rsp_valid,
  output logic [W-1:0] rsp_paddr,
  output logic [1:0]   rsp_fault,
  output logic         rsp_level,
  output logic         mem_rd_en,
  output logic         mem_wr_en,
  output logic [W-1:0] mem_addr,
  output logic [W-1:0] mem_wdata,
  input  logic [W-1:0] mem_rdata
);
  walk_state_e  state;
  logic [W-1:0] root_q;
  logic [W-1:0] va_q;
  logic         store_q;

  logic [W-1:0] dir_addr, leaf_addr, upd_word;
  fault_e       ent_fault;
  logic         need_wb;

  ptw_addr_gen #(.W(W), .IDX_W(IDX_W), .OFF_W(OFF_W)) u_addr (
    .root      (root_q),
    .vaddr     (va_q),
    .dir_word  (mem_rdata),
    .dir_addr  (dir_addr),
    .leaf_addr (leaf_addr)
  );

  ptw_entry_eval #(.W(W)) u_eval (
    .entry    (mem_rdata),
    .is_store (store_q),
    .at_leaf  (state == ST_LEAF_CHK),
    .fault    (ent_fault),
    .upd_word (upd_word),
    .need_wb  (need_wb)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      root_q <= '0;
    end else if (root_load) begin
      root_q <= root_value;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      va_q      <= '0;
      store_q   <= 1'b0;
      req_ready <= 1'b1;
      rsp_valid <= 1'b0;
      rsp_paddr <= '0;
      rsp_fault <= FLT_NONE;
      rsp_level <= 1'b0;
      mem_rd_en <= 1'b0;
      mem_wr_en <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
    end else begin
      mem_rd_en <= 1'b0;
      mem_wr_en <= 1'b0;
      rsp_valid <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (req_valid && req_ready) begin
            va_q      <= req_vaddr;
            store_q   <= req_write;
            req_ready <= 1'b0;
            state     <= ST_DIR_RD;
          end
        end
        ST_DIR_RD: begin
          mem_rd_en <= 1'b1;
          mem_addr  <= dir_addr;
          state     <= ST_LEAF_RD;
        end
        ST_LEAF_RD: begin
          state <= ST_DIR_CHK;
        end
        ST_DIR_CHK: begin
          if (ent_fault != FLT_NONE) begin
            rsp_valid <= 1'b1;
            rsp_fault <= ent_fault;
            rsp_level <= 1'b0;
            rsp_paddr <= '0;
            state     <= ST_RSP;
          end else begin
            mem_rd_en <= 1'b1;
            mem_addr  <= leaf_addr;
            state     <= ST_WB;
          end
        end
        ST_WB: begin
          if (mem_rd_en) begin
            state <= ST_LEAF_CHK;
          end else begin
            rsp_valid <= 1'b1;
            state     <= ST_RSP;
          end
        end
        ST_LEAF_CHK: begin
          rsp_fault <= ent_fault;
          if (ent_fault != FLT_NONE) begin
            rsp_valid <= 1'b1;
            rsp_level <= 1'b1;
            rsp_paddr <= '0;
            state     <= ST_RSP;
          end else begin
            rsp_level <= 1'b0;
            rsp_paddr <= {mem_rdata[W-1:OFF_W], va_q[OFF_W-1:0]};
            if (need_wb) begin
              mem_wr_en <= 1'b1;
              mem_wdata <= upd_word;
              state     <= ST_WB;
            end else begin
              rsp_valid <= 1'b1;
              state     <= ST_RSP;
            end
          end
        end
        ST_RSP: begin
          req_ready <= 1'b1;
          state     <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (rst)
    (state != ST_IDLE) |-> !req_ready); // R10
  AST_RSP_SINGLE_PULSE: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |=> !rsp_valid); // R10
  AST_RD_WR_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    !(mem_rd_en && mem_wr_en)); // R8
  AST_WB_MARKS_ACCESSED: assert property (@(posedge clk) disable iff (rst)
    mem_wr_en |-> (mem_wdata[BIT_ACCESSED] && mem_wdata[BIT_PRESENT])); // R8
  AST_WB_MARKS_MODIFIED: assert property (@(posedge clk) disable iff (rst)
    (mem_wr_en && store_q) |-> mem_wdata[BIT_MODIFIED]); // R8
  AST_PROT_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_fault == FLT_PROT) |-> !$past(mem_wr_en)); // R7
  AST_OK_AT_LEVEL0: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_fault == FLT_NONE) |-> !rsp_level); // R4
endmodule

// File: tb/tb_pt_walker.sv
`timescale 1ns/1ps
module tb_pt_walker;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        root_load = 1'b0;
  logic [31:0] root_value = '0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_vaddr = '0;
  logic        req_write = 1'b0;
  logic        rsp_valid;
  logic [31:0] rsp_paddr;
  logic [1:0]  rsp_fault;
  logic        rsp_level;
  logic        mem_rd_en, mem_wr_en;
  logic [31:0] mem_addr, mem_wdata;
  logic [31:0] mem_rdata = '0;

  logic [31:0] mem [0:4095];
  logic [31:0] root_model = '0;
  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  pt_walker dut (
    .clk(clk), .rst(rst), .root_load(root_load), .root_value(root_value),
    .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
    .req_write(req_write), .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr),
    .rsp_fault(rsp_fault), .rsp_level(rsp_level), .mem_rd_en(mem_rd_en),
    .mem_wr_en(mem_wr_en), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata)
  );

  always @(posedge clk) begin
    if (mem_rd_en) mem_rdata <= mem[mem_addr[13:2]];
    if (mem_wr_en) mem[mem_addr[13:2]] <= mem_wdata;
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic set_root(input logic [31:0] r);
    @(negedge clk);
    root_value = r;
    root_load  = 1'b1;
    @(negedge clk);
    root_load  = 1'b0;
    root_model = r;
  endtask

  task automatic run_txn(input logic [31:0] va, input logic w);
    logic [31:0] ea1, ea2, epa, ewd, dw, lw;
    logic [31:0] a1, a2, wa, wd;
    logic [1:0]  ef;
    logic        el, ewb, busy_ok;
    int          enr, nr, nw;
    ea1 = root_model + {20'd0, va[31:22], 2'b00};
    dw  = mem[ea1[13:2]];
    ea2 = '0; epa = '0; ewd = '0; ewb = 1'b0; el = 1'b0; ef = 2'b00; enr = 1;
    if (!dw[0]) begin
      ef = 2'b01;
    end else begin
      enr = 2;
      ea2 = {dw[31:12], 12'h000} + {20'd0, va[21:12], 2'b00};
      lw  = mem[ea2[13:2]];
      if (!lw[0]) begin
        ef = 2'b01; el = 1'b1;
      end else if (w && !lw[1]) begin
        ef = 2'b10; el = 1'b1;
      end else begin
        epa = {lw[31:12], va[11:0]};
        ewd = lw | 32'h20 | (w ? 32'h40 : 32'h0);
        ewb = (ewd != lw);
      end
    end

    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_vaddr = va; req_write = w; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    nr = 0; nw = 0; busy_ok = 1'b1; a1 = '0; a2 = '0; wa = '0; wd = '0;
    while (!rsp_valid) begin
      if (req_ready) busy_ok = 1'b0;
      if (mem_rd_en) begin
        if (nr == 0) a1 = mem_addr; else a2 = mem_addr;
        nr++;
      end
      if (mem_wr_en) begin
        wa = mem_addr; wd = mem_wdata; nw++;
      end
      @(negedge clk);
    end
    if (req_ready) busy_ok = 1'b0;

    chk(a1 == ea1, "R1", a1, ea1);
    if (enr == 2) chk(a2 == ea2, "R3", a2, ea2);
    if (ef == 2'b01 && !el) begin
      chk(nr == 1, "R5", nr, 1);
      chk(rsp_fault == 2'b01 && !rsp_level, "R5", {rsp_level, rsp_fault}, 3'b001);
    end else if (ef == 2'b01) begin
      chk(rsp_fault == 2'b01 && rsp_level, "R6", {rsp_level, rsp_fault}, 3'b101);
      chk(nw == 0, "R6", nw, 0);
    end else if (ef == 2'b10) begin
      chk(rsp_fault == 2'b10 && rsp_level, "R7", {rsp_level, rsp_fault}, 3'b110);
      chk(nw == 0, "R7", nw, 0);
    end else begin
      chk(rsp_fault == 2'b00 && !rsp_level, "R4", {rsp_level, rsp_fault}, 3'b000);
      chk(rsp_paddr == epa, "R4", rsp_paddr, epa);
      if (ewb) begin
        chk(nw == 1, "R8", nw, 1);
        chk(wa == ea2, "R8", wa, ea2);
        chk(wd == ewd, "R8", wd, ewd);
      end else begin
        chk(nw == 0, "R9", nw, 0);
      end
    end
    chk(busy_ok, "R10", busy_ok, 1);
    @(negedge clk);
    chk(req_ready && !rsp_valid, "R10", {req_ready, rsp_valid}, 2'b10);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] pool [0:7];
    logic [31:0] va;
    void'($urandom(32'h1234abcd));
    for (int i = 0; i < 2048; i++) begin
      mem[i] = {18'd0, ($urandom % 2) ? 2'b11 : 2'b10, 8'h00, 4'h0};
      mem[i][0] = ($urandom % 4) != 0;
    end
    for (int i = 2048; i < 4096; i++) begin
      mem[i] = $urandom & 32'hFFFF_F063;
      mem[i][0] = ($urandom % 6) != 0;
    end
    for (int i = 0; i < 8; i++) pool[i] = $urandom;

    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(req_ready && !rsp_valid && !mem_rd_en && !mem_wr_en, "R10",
        {req_ready, rsp_valid, mem_rd_en, mem_wr_en}, 4'b1000);

    va = 32'h0040_3ABC;
    mem[1] = 32'h0000_2001;
    mem[(32'h2000 >> 2) + 3] = 32'hABCDE003;
    run_txn(va, 1'b0);               // R4 R8 accessed only
    run_txn(va, 1'b1);               // R8 modified added
    run_txn(va, 1'b1);               // R9 nothing to update
    mem[(32'h2000 >> 2) + 4] = 32'h1111_1001;
    run_txn(32'h0040_4010, 1'b1);    // R7 read-only store
    run_txn(32'h0040_4010, 1'b0);    // R8 read allowed
    mem[(32'h2000 >> 2) + 5] = 32'h2222_2002;
    run_txn(32'h0040_5000, 1'b0);    // R6 leaf absent
    mem[2] = 32'h0000_3000;
    run_txn(32'h0080_0000, 1'b0);    // R5 directory absent

    set_root(32'h0000_1000);         // R2 new root
    mem[1024 + 1] = 32'h0000_3001;
    mem[(32'h3000 >> 2) + 3] = 32'h5555_5063;
    run_txn(32'h0040_3FFF, 1'b1);    // R2 R9

    for (int n = 0; n < 400; n++) begin
      if (n % 50 == 0) set_root(($urandom % 2) ? 32'h0000_1000 : 32'h0000_0000);
      va = (n % 2) ? pool[$urandom % 8] : $urandom;
      run_txn(va, $urandom % 2);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule